// File: doc/BRIEF.md
# ADC Code Trim-Correction Datapath

This block converts a raw 12-bit converter sample into a corrected value in engineering units. It handles one channel at a time. Each channel has a coefficient entry. To fill an entry, the caller supplies two factory trim readings and the channel's low and high expected readings. The block then derives three values in signed 32-bit fixed-point thousandths: a gain-error term, a scale gain and an offset. The ideal low and high codes behind the two-point fit are the same for every channel, 2064 and 3112, so their span is 1048. A channel can also be flagged as bypassed. A bypassed channel skips the trim correction, and its raw code goes straight to the scaling step.

In operation a request carries a channel index and a raw code. For a corrected channel the block computes `(raw*1000 - offset) / gainError`. If that quotient is negative, the block returns 0 and raises a clamp flag. Otherwise it returns `(corrected*gain)/1000`. A bypassed channel skips the first division. Every division goes through one shared restoring divider. The divider resolves one quotient bit per cycle and truncates toward zero. The block is busy from the moment it takes a command until its one-cycle `done` strobe. Any command that arrives while it is busy is dropped.

Top module: `adc_trim_corrector`

## Requirements
- R1: After reset, busy, done, result and clamped are all 0, and every channel is bypassed with gain 0, so a conversion on an uncalibrated channel returns 0 with clamped low.
- R2: A calibration command stores gainError = 1000 + (1000*(trimHi-trimLo))/1048, gain = ((refHi-refLo)*1000)/1048 and offset = trimLo*1000 - (gainError-1000)*2064 for the addressed channel. Its done strobe is observed 66 clock edges after the accepting edge, with result equal to the new gain and clamped low.
- R3: On a corrected channel a conversion returns ((raw*1000-offset)/gainError * gain)/1000, with done 66 edges after acceptance and clamped low.
- R4: When the corrected quotient of a corrected channel is negative, the conversion ends after 33 edges with result 0 and clamped high.
- R5: Every division truncates toward zero, including negative trim differences; a negative numerator whose magnitude is below the divisor gives a corrected code of 0, not a clamp.
- R6: On a bypassed channel a conversion returns (raw*gain)/1000 with done 33 edges after acceptance.
- R7: busy is high from the cycle after a command is accepted until the cycle that done is high; calibration or conversion commands arriving while busy produce no done and change no stored coefficient.
- R8: When a calibration command and a conversion request are both presented in the same idle cycle, the calibration is taken and the conversion request is dropped.
- R9: done is a single-cycle pulse, and result and clamped hold their value until the next done.
- R10: The 16 channel entries are independent: calibrating one channel leaves the results of the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_valid | input | 1 | Calibration command strobe |
| cal_chan | input | 4 | Channel whose entry is written |
| cal_trim_lo | input | 8 | Factory trim reading at the low point |
| cal_trim_hi | input | 8 | Factory trim reading at the high point |
| cal_ref_lo | input | 16 | Expected reading at the low ideal code |
| cal_ref_hi | input | 16 | Expected reading at the high ideal code |
| cal_bypass | input | 1 | Mark channel as skipping trim correction |
| req_valid | input | 1 | Conversion request strobe |
| req_chan | input | 4 | Channel of the request |
| req_code | input | 12 | Raw converter code |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 32 | Signed result (gain after calibration, scaled value after conversion) |
| clamped | output | 1 | Corrected code was negative and the result was forced to 0 |

## Verification
The bench uses trim pairs whose offset pushes small codes negative. A design that compares before dividing, or that floors instead of truncating, would clamp the borderline code 181, and a missing clamp would emit a large negative scaled value. Trim readings that fall from low to high check that a sign-magnitude divider restores the quotient sign. An unsigned divider would produce a huge gain error. The bench pulses commands mid-operation and pairs a calibration with a request in the same cycle. These catch a controller that re-launches the shared divider, corrupts a stored entry, or serves the request ahead of the calibration. Exact done latencies of 33 and 66 edges expose an off-by-one in the bit counter or a skipped first division on bypassed channels.

// File: rtl/adc_trim_pkg.sv
package adc_trim_pkg;
  localparam int DW     = 32;
  localparam int SCALE  = 1000;
  localparam int X_LO   = 2064;
  localparam int X_HI   = 3112;
  localparam int X_SPAN = X_HI - X_LO;

  typedef logic signed [DW-1:0] sword_t;

  typedef struct packed {
    sword_t gerr;
    sword_t gain;
    sword_t offs;
    logic   bypass;
  } coef_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CAL_K, S_CAL_G, S_CNV_A, S_CNV_B
  } phase_t;

  // numerator of the gain-error quotient
  function automatic sword_t f_span_num(sword_t hi, sword_t lo);
    return (hi - lo) * sword_t'(SCALE);
  endfunction

  // offset term from the low trim and the gain error
  function automatic sword_t f_offset(sword_t t_lo, sword_t k);
    return t_lo * sword_t'(SCALE) - (k - sword_t'(SCALE)) * sword_t'(X_LO);
  endfunction

  // numerator of the corrected-code quotient
  function automatic sword_t f_corr_num(sword_t raw, sword_t offs);
    return raw * sword_t'(SCALE) - offs;
  endfunction
endpackage

// File: rtl/adc_div_restoring.sv
module adc_div_restoring
  import adc_trim_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  sword_t num,
  input  sword_t den,
  output logic   busy,
  output logic   fin,
  output sword_t quot
);
  localparam int CW = $clog2(DW);

  logic          run;
  logic          fin_q;
  logic [CW-1:0] cnt;
  logic [DW-1:0] rem;
  logic [DW-1:0] q;
  logic [DW-1:0] d;
  logic          neg;
  logic          dz;
  logic [DW:0]   shifted;
  logic [DW:0]   diff;
  logic [DW-1:0] num_mag;
  logic [DW-1:0] den_mag;

  assign num_mag = num[DW-1] ? DW'(-num) : num;
  assign den_mag = den[DW-1] ? DW'(-den) : den;
  assign shifted = {rem, q[DW-1]};
  assign diff    = shifted - {1'b0, d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      fin_q <= 1'b0;
      cnt   <= '0;
      rem   <= '0;
      q     <= '0;
      d     <= '0;
      neg   <= 1'b0;
      dz    <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (start && !run) begin
        run <= 1'b1;
        cnt <= '0;
        rem <= '0;
        q   <= num_mag;
        d   <= den_mag;
        neg <= num[DW-1] ^ den[DW-1];
        dz  <= (den == '0);
      end else if (run) begin
        if (!diff[DW]) begin
          rem <= diff[DW-1:0];
          q   <= {q[DW-2:0], 1'b1};
        end else begin
          rem <= shifted[DW-1:0];
          q   <= {q[DW-2:0], 1'b0};
        end
        cnt <= cnt + 1'b1;
        if (cnt == CW'(DW-1)) begin
          run   <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign busy = run;
  assign fin  = fin_q;
  assign quot = dz ? '0 : (neg ? -$signed(q) : $signed(q));
endmodule

// File: rtl/adc_coef_store.sv
module adc_coef_store
  import adc_trim_pkg::*;
#(
  parameter int CH_N  = 16,
  parameter int CH_AW = $clog2(CH_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CH_AW-1:0] wr_addr,
  input  coef_t            wr_data,
  input  logic [CH_AW-1:0] rd_addr,
  output coef_t            rd_data
);
  localparam coef_t COEF_RST = '{gerr: sword_t'(SCALE), gain: '0, offs: '0, bypass: 1'b1};

  coef_t ent [CH_N];

  for (genvar i = 0; i < CH_N; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ent[i] <= COEF_RST;
      else if (wr_en && (wr_addr == CH_AW'(i)))
        ent[i] <= wr_data;
    end
  end

  assign rd_data = ent[rd_addr];
endmodule

// File: rtl/adc_trim_ctrl.sv
module adc_trim_ctrl
  import adc_trim_pkg::*;
#(
  parameter int CH_AW  = 4,
  parameter int TRIM_W = 8,
  parameter int REF_W  = 16,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_valid,
  input  logic [CH_AW-1:0]  cal_chan,
  input  logic [TRIM_W-1:0] cal_trim_lo,
  input  logic [TRIM_W-1:0] cal_trim_hi,
  input  logic [REF_W-1:0]  cal_ref_lo,
  input  logic [REF_W-1:0]  cal_ref_hi,
  input  logic              cal_bypass,
  input  logic              req_valid,
  input  logic [CODE_W-1:0] req_code,
  input  coef_t             rd_coef,
  input  logic              div_busy,
  input  logic              div_fin,
  input  sword_t            div_quot,
  output logic              div_start,
  output sword_t            div_num,
  output sword_t            div_den,
  output logic              wr_en,
  output logic [CH_AW-1:0]  wr_addr,
  output coef_t             wr_coef,
  output logic              busy,
  output logic              done,
  output sword_t            result,
  output logic              clamped
);
  phase_t           st;
  logic [CH_AW-1:0] ch_q;
  sword_t           tlo_q;
  sword_t           vdiff_q;
  logic             byp_q;
  sword_t           kq;
  sword_t           gain_q;
  logic             done_q;
  sword_t           res_q;
  logic             clamp_q;

  logic   idle, acc_cal, acc_req, quot_neg;
  sword_t raw_x, tlo_x, thi_x, vlo_x, vhi_x;

  assign idle     = (st == S_IDLE) && !div_busy;
  assign acc_cal  = idle && cal_valid;
  assign acc_req  = idle && req_valid && !cal_valid;
  assign quot_neg = div_quot[DW-1];

  assign raw_x = sword_t'({{(DW-CODE_W){1'b0}}, req_code});
  assign tlo_x = sword_t'({{(DW-TRIM_W){1'b0}}, cal_trim_lo});
  assign thi_x = sword_t'({{(DW-TRIM_W){1'b0}}, cal_trim_hi});
  assign vlo_x = sword_t'({{(DW-REF_W){1'b0}}, cal_ref_lo});
  assign vhi_x = sword_t'({{(DW-REF_W){1'b0}}, cal_ref_hi});

  // operand selection for the shared divider
  always_comb begin
    div_start = 1'b0;
    div_num   = '0;
    div_den   = '0;
    if (acc_cal) begin
      div_start = 1'b1;
      div_num   = f_span_num(thi_x, tlo_x);
      div_den   = sword_t'(X_SPAN);
    end else if (acc_req) begin
      div_start = 1'b1;
      if (rd_coef.bypass) begin
        div_num = raw_x * rd_coef.gain;
        div_den = sword_t'(SCALE);
      end else begin
        div_num = f_corr_num(raw_x, rd_coef.offs);
        div_den = rd_coef.gerr;
      end
    end else if (st == S_CAL_K && div_fin) begin
      div_start = 1'b1;
      div_num   = vdiff_q * sword_t'(SCALE);
      div_den   = sword_t'(X_SPAN);
    end else if (st == S_CNV_A && div_fin && !quot_neg) begin
      div_start = 1'b1;
      div_num   = div_quot * gain_q;
      div_den   = sword_t'(SCALE);
    end
  end

  always_comb begin
    wr_en          = (st == S_CAL_G) && div_fin;
    wr_addr        = ch_q;
    wr_coef.gerr   = kq;
    wr_coef.gain   = div_quot;
    wr_coef.offs   = f_offset(tlo_q, kq);
    wr_coef.bypass = byp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ch_q    <= '0;
      tlo_q   <= '0;
      vdiff_q <= '0;
      byp_q   <= 1'b0;
      kq      <= '0;
      gain_q  <= '0;
      done_q  <= 1'b0;
      res_q   <= '0;
      clamp_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (acc_cal) begin
            ch_q    <= cal_chan;
            tlo_q   <= tlo_x;
            vdiff_q <= vhi_x - vlo_x;
            byp_q   <= cal_bypass;
            st      <= S_CAL_K;
          end else if (acc_req) begin
            gain_q <= rd_coef.gain;
            st     <= rd_coef.bypass ? S_CNV_B : S_CNV_A;
          end
        end
        S_CAL_K: if (div_fin) begin
          kq <= sword_t'(SCALE) + div_quot;
          st <= S_CAL_G;
        end
        S_CAL_G: if (div_fin) begin
          done_q  <= 1'b1;
          res_q   <= div_quot;
          clamp_q <= 1'b0;
          st      <= S_IDLE;
        end
        S_CNV_A: if (div_fin) begin
          if (quot_neg) begin
            done_q  <= 1'b1;
            res_q   <= '0;
            clamp_q <= 1'b1;
            st      <= S_IDLE;
          end else begin
            st <= S_CNV_B;
          end
        end
        S_CNV_B: if (div_fin) begin
          done_q  <= 1'b1;
          res_q   <= div_quot;
          clamp_q <= 1'b0;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st != S_IDLE);
  assign done    = done_q;
  assign result  = res_q;
  assign clamped = clamp_q;
endmodule

// File: rtl/adc_trim_corrector.sv
module adc_trim_corrector
  import adc_trim_pkg::*;
#(
  parameter int CH_N   = 16,
  parameter int TRIM_W = 8,
  parameter int REF_W  = 16,
  parameter int CODE_W = 12,
  localparam int CH_AW = $clog2(CH_N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cal_valid,
  input  logic [CH_AW-1:0]     cal_chan,
  input  logic [TRIM_W-1:0]    cal_trim_lo,
  input  logic [TRIM_W-1:0]    cal_trim_hi,
  input  logic [REF_W-1:0]     cal_ref_lo,
  input  logic [REF_W-1:0]     cal_ref_hi,
  input  logic                 cal_bypass,
  input  logic                 req_valid,
  input  logic [CH_AW-1:0]     req_chan,
  input  logic [CODE_W-1:0]    req_code,
  output logic                 busy,
  output logic                 done,
  output logic signed [31:0]   result,
  output logic                 clamped
);
  coef_t            rd_coef;
  coef_t            wr_coef;
  logic             wr_en;
  logic [CH_AW-1:0] wr_addr;
  logic             div_start, div_busy, div_fin;
  sword_t           div_num, div_den, div_quot;

  adc_coef_store #(.CH_N(CH_N), .CH_AW(CH_AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_coef),
    .rd_addr(req_chan), .rd_data(rd_coef)
  );

  adc_div_restoring u_div (
    .clk(clk), .rst_n(rst_n),
    .start(div_start), .num(div_num), .den(div_den),
    .busy(div_busy), .fin(div_fin), .quot(div_quot)
  );

  adc_trim_ctrl #(.CH_AW(CH_AW), .TRIM_W(TRIM_W), .REF_W(REF_W), .CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cal_valid(cal_valid), .cal_chan(cal_chan),
    .cal_trim_lo(cal_trim_lo), .cal_trim_hi(cal_trim_hi),
    .cal_ref_lo(cal_ref_lo), .cal_ref_hi(cal_ref_hi), .cal_bypass(cal_bypass),
    .req_valid(req_valid), .req_code(req_code),
    .rd_coef(rd_coef),
    .div_busy(div_busy), .div_fin(div_fin), .div_quot(div_quot),
    .div_start(div_start), .div_num(div_num), .div_den(div_den),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_coef(wr_coef),
    .busy(busy), .done(done), .result(result), .clamped(clamped)
  );
endmodule

// File: rtl/adc_trim_corrector_chk.sv
module adc_trim_corrector_chk (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic signed [31:0] result,
  input logic               clamped,
  input logic               div_busy,
  input logic               div_fin
);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(clamped)));

  a_r4_clamp_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && clamped) |-> (result == 32'sd0));

  a_r7_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_busy_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r7_divider_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> busy);

  a_r3_finish_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(div_fin));
endmodule

bind adc_trim_corrector adc_trim_corrector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .result(result),
  .clamped(clamped), .div_busy(div_busy), .div_fin(div_fin)
);

// File: tb/test_adc_trim_corrector.sv
module test_adc_trim_corrector;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               cal_valid = 1'b0;
  logic [3:0]         cal_chan = '0;
  logic [7:0]         cal_trim_lo = '0;
  logic [7:0]         cal_trim_hi = '0;
  logic [15:0]        cal_ref_lo = '0;
  logic [15:0]        cal_ref_hi = '0;
  logic               cal_bypass = 1'b0;
  logic               req_valid = 1'b0;
  logic [3:0]         req_chan = '0;
  logic [11:0]        req_code = '0;
  logic               busy, done, clamped;
  logic signed [31:0] result;

  int nchk = 0;
  int nerr = 0;
  int mk [16];
  int mg [16];
  int mo [16];
  bit mb [16];

  always #10 clk = ~clk;

  adc_trim_corrector i_adc_trim_corrector (
    .clk(clk), .rst_n(rst_n), .cal_valid(cal_valid), .cal_chan(cal_chan),
    .cal_trim_lo(cal_trim_lo), .cal_trim_hi(cal_trim_hi),
    .cal_ref_lo(cal_ref_lo), .cal_ref_hi(cal_ref_hi), .cal_bypass(cal_bypass),
    .req_valid(req_valid), .req_chan(req_chan), .req_code(req_code),
    .busy(busy), .done(done), .result(result), .clamped(clamped)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one command cycle; returns at the negedge after the accepting edge
  task automatic fire(input bit c, input bit r, input int cch, input int tlo, input int thi,
                      input int vlo, input int vhi, input bit byp, input int rch, input int raw);
    @(negedge clk);
    cal_valid = c; cal_chan = 4'(cch); cal_trim_lo = 8'(tlo); cal_trim_hi = 8'(thi);
    cal_ref_lo = 16'(vlo); cal_ref_hi = 16'(vhi); cal_bypass = byp;
    req_valid = r; req_chan = 4'(rch); req_code = 12'(raw);
    @(posedge clk);
    @(negedge clk);
    cal_valid = 1'b0; req_valid = 1'b0;
  endtask

  task automatic wait_done(input string tag, output int n);
    n = 0;
    chk({tag, " R7 busy after accept"}, busy, 1);
    while (!done && n < 300) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    if (n >= 300) chk({tag, " timeout"}, 0, 1);
  endtask

  task automatic model_cal(input int ch, input int tlo, input int thi, input int vlo,
                           input int vhi, input bit byp);
    mk[ch] = 1000 + (1000 * (thi - tlo)) / 1048;
    mg[ch] = ((vhi - vlo) * 1000) / 1048;
    mo[ch] = tlo * 1000 - (mk[ch] - 1000) * 2064;
    mb[ch] = byp;
  endtask

  task automatic t_cal(input int ch, input int tlo, input int thi, input int vlo,
                       input int vhi, input bit byp);
    int n;
    model_cal(ch, tlo, thi, vlo, vhi, byp);
    fire(1, 0, ch, tlo, thi, vlo, vhi, byp, 0, 0);
    wait_done("R2", n);
    chk("R2 cal latency", n, 66);
    chk("R2 cal result gain", result, mg[ch]);
    chk("R2 cal clamped", clamped, 0);
  endtask

  task automatic t_conv(input string tag, input int ch, input int raw);
    int n, c, er, lat;
    bit ec;
    if (mb[ch]) begin
      er = (raw * mg[ch]) / 1000; ec = 0; lat = 33;
    end else begin
      c = (raw * 1000 - mo[ch]) / mk[ch];
      if (c < 0) begin er = 0; ec = 1; lat = 33; end
      else begin er = (c * mg[ch]) / 1000; ec = 0; lat = 66; end
    end
    fire(0, 1, 0, 0, 0, 0, 0, 0, ch, raw);
    wait_done(tag, n);
    chk({tag, " latency"}, n, lat);
    chk({tag, " result"}, result, er);
    chk({tag, " clamped"}, clamped, ec);
    @(negedge clk);
    chk("R9 done pulse low", done, 0);
    chk("R9 result held", result, er);
    chk("R9 clamped held", clamped, ec);
  endtask

  task automatic sc_reset;
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 result", result, 0);
    chk("R1 clamped", clamped, 0);
    t_conv("R1 uncal conv", 5, 3000);
  endtask

  task automatic sc_basic;
    t_cal(2, 200, 210, 630, 950, 0);
    t_conv("R3 conv mid", 2, 3000);
    t_conv("R3 conv full", 2, 4095);
  endtask

  task automatic sc_clamp;
    t_conv("R4 clamp", 2, 100);
    t_conv("R4 clamp zero code", 2, 0);
  endtask

  task automatic sc_trunc;
    t_conv("R5 small negative not clamped", 2, 181);
    t_cal(9, 50, 20, 1260, 1900, 0);
    t_conv("R5 falling trims", 9, 2500);
  endtask

  task automatic sc_bypass;
    t_cal(6, 0, 0, 5670, 8550, 1);
    t_conv("R6 bypass", 6, 4000);
    t_conv("R6 bypass zero", 6, 0);
  endtask

  task automatic sc_busy_ignore;
    int n, er, extra;
    er = (((3000 * 1000 - mo[2]) / mk[2]) * mg[2]) / 1000;
    fire(0, 1, 0, 0, 0, 0, 0, 0, 2, 3000);
    n = 0;
    while (!done && n < 300) begin
      @(posedge clk); n++;
      @(negedge clk);
      req_valid = (n == 5);  req_chan = 4'd6; req_code = 12'd4000;
      cal_valid = (n == 10); cal_chan = 4'd2; cal_trim_lo = 8'd0; cal_trim_hi = 8'd100;
      cal_ref_lo = 16'd0; cal_ref_hi = 16'd9000; cal_bypass = 1'b1;
    end
    req_valid = 1'b0; cal_valid = 1'b0;
    chk("R7 latency with noise", n, 66);
    chk("R7 result of first request", result, er);
    extra = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R7 no extra done", extra, 0);
    t_conv("R7 coefficients untouched", 2, 3000);
  endtask

  task automatic sc_priority;
    int n, extra;
    model_cal(11, 30, 90, 3150, 4750, 0);
    fire(1, 1, 11, 30, 90, 3150, 4750, 0, 2, 3000);
    wait_done("R8", n);
    chk("R8 calibration latency", n, 66);
    chk("R8 calibration result", result, mg[11]);
    extra = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R8 request dropped", extra, 0);
  endtask

  task automatic sc_isolation;
    t_conv("R10 ch2 after others", 2, 3000);
    t_cal(3, 120, 140, 3465, 5225, 0);
    t_conv("R10 ch3", 3, 3500);
    t_conv("R10 ch2 unchanged", 2, 3000);
    t_conv("R10 ch11", 11, 2600);
    t_conv("R10 ch5 still reset", 5, 1234);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mk[i] = 1000; mg[i] = 0; mo[i] = 0; mb[i] = 1;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    sc_reset();
    sc_basic();
    sc_clamp();
    sc_trunc();
    sc_bypass();
    sc_busy_ignore();
    sc_priority();
    sc_isolation();
    summary();
  end
endmodule